// File: doc/BRIEF.md
# Program/Data Memory Partition Decoder

This block sits between a processor core and a byte-wide memory system. On each clock it looks at the current access request: an instruction fetch, a data read or a data write, together with a 16-bit address. It decides whether the access goes to the internal nonvolatile RAM, to the expanded external bus, or to the real-time clock window. A single internal RAM can either hold two separate 64K-sized spaces, one for program and one for data, each capped at half the fitted capacity. It can also be shared as one space that a boundary register splits. In the shared case the part below the boundary is program memory, and data writes into it are suppressed.

Instruction fetches never leave the module. A fetch that does not land in internal RAM is refused: a fixed filler byte is presented and a one-cycle violation flag is raised. A peripheral-enable bit opens a 4K data window onto the clock, and this window takes precedence over every other data mapping. The decision is registered, so every output reflects the request presented at the preceding clock edge. Reset is asynchronous and drives every active-low enable high.

The decision register is a state machine with eight states. `ST_HOLD` is entered on reset. `ST_IDLE` means no access. `ST_RAM_RD` and `ST_RAM_WR` are internal RAM cycles. `ST_EXT` is an expanded-bus cycle and `ST_RTC` is a clock select. `ST_DENY_WR` is a suppressed program-region write and `ST_DENY_FETCH` is a refused fetch. Reset moves any state to `ST_HOLD`. At every clock edge without reset, including the first one after `ST_HOLD`, the next state is the outcome decoded from the request sampled at that edge, so any state can follow any other.

Top module: `mem_partition_decoder`

## Requirements
- R1: While `rst` is high, `ram_ce_n`, `ram_we_n`, `ext_ce_n` and `rtc_ce_n` are 1, `viol` is 0, `fill_data` is 0 and `ram_addr` is 0. The same holds one clock after a request of kind 2'b00 (no access).
- R2: Access kinds are encoded as 2'b01 fetch, 2'b10 data read and 2'b11 data write. Every output reflects the request sampled at the previous rising edge. Capacity is selected by `size_sel`: 0 gives 32K, 1 gives 64K, and 2 or 3 give 128K. In two-space mode (`unsplit_mode`=1), a fetch below half the capacity enables the RAM with `ram_addr` equal to the address.
- R3: In two-space mode, a data access below half the capacity enables the RAM at `ram_addr` = half capacity + address. `ram_we_n` is 0 for a write and 1 for a read.
- R4: A data access that is not mapped to internal RAM or to the clock window drives `ext_ce_n` low, with the RAM and clock enables high.
- R5: A fetch that is not mapped to internal RAM never drives `ext_ce_n` low. It raises `viol` and presents `fill_data` = 8'hFF; `fill_data` is 0 at all other times.
- R6: In shared mode (`unsplit_mode`=0), the boundary is `boundary`×2048. A fetch below both the boundary and the capacity enables the RAM at the same address. A fetch at or above the boundary is refused as in R5.
- R7: In shared mode, any data access below the capacity that is not a protected write enables the RAM at the same address. This includes reads below the boundary. Data addresses at or above the capacity go to the external bus.
- R8: In shared mode, a data write below the boundary keeps `ram_ce_n` and `ram_we_n` high and raises `viol` for exactly one cycle unless the next request also violates.
- R9: With `periph_en`=1, a data access to addresses B000h–BFFFh drives only `rtc_ce_n` low, even inside the protected region, and `viol` stays 0. Fetches ignore the window. With `periph_en`=0, the same address decodes normally.
- R10: In the 128K configuration, `unsplit_mode`=0 is ignored and decoding follows two-space mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| acc_kind | input | 2 | Request kind: 00 none, 01 fetch, 10 read, 11 write |
| addr | input | 16 | Request address |
| unsplit_mode | input | 1 | 1 selects two separate spaces, 0 selects one shared split space |
| boundary | input | 5 | Program/data boundary in 2K units |
| periph_en | input | 1 | Opens the clock window in data space |
| size_sel | input | 2 | Fitted RAM capacity select |
| ram_ce_n | output | 1 | Internal RAM chip enable, active low |
| ram_we_n | output | 1 | Internal RAM write enable, active low |
| ram_addr | output | 17 | Physical RAM address, 0 when RAM is idle |
| ext_ce_n | output | 1 | Expanded-bus cycle request, active low |
| rtc_ce_n | output | 1 | Clock select, active low |
| viol | output | 1 | Access-violation flag |
| fill_data | output | 8 | Filler byte for a refused fetch, else 0 |

## Verification
Two functions can act on one request: write protection of the program region and the clock window. A data write to B000h–BFFFh with a boundary set above C000h lands in both at once. The bench provokes this with `periph_en` at 1 and expects only the clock select, with `viol` low. It then repeats the same write with `periph_en` at 0 and expects a suppressed write with the violation flag. The reset path is also exercised with a request held on the inputs, to confirm that forcing reset outranks a pending decode.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    typedef enum logic [1:0] {
        K_NONE  = 2'b00,
        K_FETCH = 2'b01,
        K_READ  = 2'b10,
        K_WRITE = 2'b11
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_IDLE,
        ST_RAM_RD,
        ST_RAM_WR,
        ST_EXT,
        ST_RTC,
        ST_DENY_WR,
        ST_DENY_FETCH
    } mpd_state_t;

endpackage

// File: rtl/mpd_region_map.sv
module mpd_region_map #(
    parameter int AW        = 16,
    parameter int GRAN_LOG2 = 11,
    parameter int BASE_LOG2 = 15,
    parameter int RTC_BASE  = 'hB000,
    parameter int RTC_SPAN  = 'h1000,
    localparam int BND_W    = AW - GRAN_LOG2,
    localparam int RAM_AW   = BASE_LOG2 + 2,
    localparam int WW       = RAM_AW + 1
) (
    input  logic [AW-1:0]     addr,
    input  logic              unsplit_mode,
    input  logic [BND_W-1:0]  boundary,
    input  logic              periph_en,
    input  logic [1:0]        size_sel,
    output logic              fetch_ok,
    output logic [RAM_AW-1:0] fetch_phys,
    output logic              data_ram,
    output logic [RAM_AW-1:0] data_phys,
    output logic              data_protected,
    output logic              rtc_hit
);

    logic [1:0]    eff_sel;
    logic          split_on;
    logic [WW-1:0] cap, half, bnd, a_w, dphys_w;

    always_comb begin
        eff_sel  = (size_sel >= 2'd2) ? 2'd2 : size_sel;
        split_on = !unsplit_mode && (eff_sel != 2'd2);
        cap      = WW'(1) << (BASE_LOG2 + int'(eff_sel));
        half     = cap >> 1;
        bnd      = WW'(boundary) << GRAN_LOG2;
        a_w      = WW'(addr);
        rtc_hit  = periph_en && (a_w >= WW'(RTC_BASE)) && (a_w < WW'(RTC_BASE + RTC_SPAN));
        if (split_on) begin
            fetch_ok       = (a_w < bnd) && (a_w < cap);
            data_ram       = (a_w < cap);
            dphys_w        = a_w;
            data_protected = (a_w < bnd);
        end else begin
            fetch_ok       = (a_w < half);
            data_ram       = (a_w < half);
            dphys_w        = half + a_w;
            data_protected = 1'b0;
        end
        fetch_phys = a_w[RAM_AW-1:0];
        data_phys  = dphys_w[RAM_AW-1:0];
    end

endmodule

// File: rtl/mpd_access_judge.sv
module mpd_access_judge
    import mpd_pkg::*;
#(
    parameter int RAM_AW = 17
) (
    input  acc_kind_t         kind,
    input  logic              fetch_ok,
    input  logic [RAM_AW-1:0] fetch_phys,
    input  logic              data_ram,
    input  logic [RAM_AW-1:0] data_phys,
    input  logic              data_protected,
    input  logic              rtc_hit,
    output mpd_state_t        outcome,
    output logic [RAM_AW-1:0] phys
);

    always_comb begin
        outcome = ST_IDLE;
        phys    = '0;
        unique case (kind)
            K_NONE: outcome = ST_IDLE;
            K_FETCH: begin
                if (fetch_ok) begin
                    outcome = ST_RAM_RD;
                    phys    = fetch_phys;
                end else begin
                    outcome = ST_DENY_FETCH;
                end
            end
            K_READ: begin
                if (rtc_hit)       outcome = ST_RTC;
                else if (data_ram) begin
                    outcome = ST_RAM_RD;
                    phys    = data_phys;
                end else           outcome = ST_EXT;
            end
            K_WRITE: begin
                if (rtc_hit)             outcome = ST_RTC;
                else if (data_protected) outcome = ST_DENY_WR;
                else if (data_ram) begin
                    outcome = ST_RAM_WR;
                    phys    = data_phys;
                end else                 outcome = ST_EXT;
            end
        endcase
    end

endmodule

// File: rtl/mpd_seq.sv
module mpd_seq
    import mpd_pkg::*;
#(
    parameter int         RAM_AW    = 17,
    parameter logic [7:0] FILL_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_t         req_kind,
    input  mpd_state_t        outcome,
    input  logic [RAM_AW-1:0] phys,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ext_ce_n,
    output logic              rtc_ce_n,
    output logic              viol,
    output logic [7:0]        fill_data
);

    mpd_state_t        state;
    logic [RAM_AW-1:0] addr_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state  <= ST_HOLD;
            addr_q <= '0;
        end else begin
            state  <= outcome;
            addr_q <= phys;
        end
    end

    always_comb begin
        ram_ce_n  = 1'b1;
        ram_we_n  = 1'b1;
        ram_addr  = '0;
        ext_ce_n  = 1'b1;
        rtc_ce_n  = 1'b1;
        viol      = 1'b0;
        fill_data = '0;
        unique case (state)
            ST_HOLD, ST_IDLE: ;
            ST_RAM_RD: begin
                ram_ce_n = 1'b0;
                ram_addr = addr_q;
            end
            ST_RAM_WR: begin
                ram_ce_n = 1'b0;
                ram_we_n = 1'b0;
                ram_addr = addr_q;
            end
            ST_EXT:     ext_ce_n = 1'b0;
            ST_RTC:     rtc_ce_n = 1'b0;
            ST_DENY_WR: viol = 1'b1;
            ST_DENY_FETCH: begin
                viol      = 1'b1;
                fill_data = FILL_BYTE;
            end
        endcase
    end

    // R1
    hold_inactive_chk: assert property (@(posedge clk)
        rst |=> (ram_ce_n && ram_we_n && ext_ce_n && rtc_ce_n && !viol));

    // R5
    fetch_no_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (req_kind == K_FETCH) |=> ext_ce_n);

    // R8
    we_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> $past(req_kind == K_WRITE));

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~ram_ce_n, ~ext_ce_n, ~rtc_ce_n, viol}) <= 1);

    // R5
    fill_viol_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_data != 8'h00) |-> viol);

endmodule

// File: rtl/mem_partition_decoder.sv
module mem_partition_decoder
    import mpd_pkg::*;
#(
    parameter int         AW        = 16,
    parameter int         GRAN_LOG2 = 11,
    parameter int         BASE_LOG2 = 15,
    parameter int         RTC_BASE  = 'hB000,
    parameter int         RTC_SPAN  = 'h1000,
    parameter logic [7:0] FILL_BYTE = 8'hFF,
    localparam int        BND_W     = AW - GRAN_LOG2,
    localparam int        RAM_AW    = BASE_LOG2 + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        acc_kind,
    input  logic [AW-1:0]     addr,
    input  logic              unsplit_mode,
    input  logic [BND_W-1:0]  boundary,
    input  logic              periph_en,
    input  logic [1:0]        size_sel,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ext_ce_n,
    output logic              rtc_ce_n,
    output logic              viol,
    output logic [7:0]        fill_data
);

    acc_kind_t         kind;
    logic              fetch_ok, data_ram, data_protected, rtc_hit;
    logic [RAM_AW-1:0] fetch_phys, data_phys, phys;
    mpd_state_t        outcome;

    assign kind = acc_kind_t'(acc_kind);

    mpd_region_map #(
        .AW(AW), .GRAN_LOG2(GRAN_LOG2), .BASE_LOG2(BASE_LOG2),
        .RTC_BASE(RTC_BASE), .RTC_SPAN(RTC_SPAN)
    ) u_map (
        .addr(addr), .unsplit_mode(unsplit_mode), .boundary(boundary),
        .periph_en(periph_en), .size_sel(size_sel),
        .fetch_ok(fetch_ok), .fetch_phys(fetch_phys),
        .data_ram(data_ram), .data_phys(data_phys),
        .data_protected(data_protected), .rtc_hit(rtc_hit)
    );

    mpd_access_judge #(.RAM_AW(RAM_AW)) u_judge (
        .kind(kind), .fetch_ok(fetch_ok), .fetch_phys(fetch_phys),
        .data_ram(data_ram), .data_phys(data_phys),
        .data_protected(data_protected), .rtc_hit(rtc_hit),
        .outcome(outcome), .phys(phys)
    );

    mpd_seq #(.RAM_AW(RAM_AW), .FILL_BYTE(FILL_BYTE)) u_seq (
        .clk(clk), .rst(rst), .req_kind(kind), .outcome(outcome), .phys(phys),
        .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_addr(ram_addr),
        .ext_ce_n(ext_ce_n), .rtc_ce_n(rtc_ce_n), .viol(viol),
        .fill_data(fill_data)
    );

endmodule

// File: tb/mem_partition_decoder_tb.sv
module mem_partition_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_kind = 2'b00;
    logic [15:0] addr = '0;
    logic        unsplit_mode = 1'b1;
    logic [4:0]  boundary = '0;
    logic        periph_en = 1'b0;
    logic [1:0]  size_sel = 2'd1;
    logic        ram_ce_n, ram_we_n, ext_ce_n, rtc_ce_n, viol;
    logic [16:0] ram_addr;
    logic [7:0]  fill_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    localparam logic [1:0] NONE = 2'b00, FE = 2'b01, RD = 2'b10, WR = 2'b11;

    mem_partition_decoder u_dut (
        .clk(clk), .rst(rst), .acc_kind(acc_kind), .addr(addr),
        .unsplit_mode(unsplit_mode), .boundary(boundary), .periph_en(periph_en),
        .size_sel(size_sel), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
        .ram_addr(ram_addr), .ext_ce_n(ext_ce_n), .rtc_ce_n(rtc_ce_n),
        .viol(viol), .fill_data(fill_data)
    );

    always #5 clk = ~clk;

    // outputs packed: {ce, we, ext, rtc, viol, fill[7:0], ram_addr[16:0]}
    task automatic expect_out(input string tag, input logic ce, input logic we,
                              input logic ext, input logic rtc, input logic v,
                              input logic [7:0] fill, input logic [16:0] ra);
        logic [29:0] act, exp;
        act = {ram_ce_n, ram_we_n, ext_ce_n, rtc_ce_n, viol, fill_data, ram_addr};
        exp = {ce, we, ext, rtc, v, fill, ra};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, result sampled at the next falling edge
    task automatic access(input logic [1:0] k, input logic [15:0] a);
        @(negedge clk);
        acc_kind = k;
        addr     = a;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        acc_kind = WR; addr = 16'h0010;
        repeat (3) @(negedge clk);
        expect_out("R1 reset with pending write", 1, 1, 1, 1, 0, 8'h00, 17'h0);
        rst = 1'b0;
        access(NONE, 16'h0000);
        expect_out("R1 no access", 1, 1, 1, 1, 0, 8'h00, 17'h0);
    endtask

    task automatic t_unsplit;
        unsplit_mode = 1; size_sel = 2'd1; periph_en = 0;
        access(FE, 16'h1234);
        expect_out("R2 fetch low", 0, 1, 1, 1, 0, 8'h00, 17'h01234);
        access(RD, 16'h0100);
        expect_out("R3 data read", 0, 1, 1, 1, 0, 8'h00, 17'h08100);
        access(WR, 16'h7FFF);
        expect_out("R3 data write top", 0, 0, 1, 1, 0, 8'h00, 17'h0FFFF);
        access(RD, 16'h8000);
        expect_out("R4 data above half", 1, 1, 0, 1, 0, 8'h00, 17'h0);
        access(FE, 16'h9000);
        expect_out("R5 fetch outside", 1, 1, 1, 1, 1, 8'hFF, 17'h0);
        size_sel = 2'd0;
        access(RD, 16'h3FFF);
        expect_out("R3 32K data top", 0, 1, 1, 1, 0, 8'h00, 17'h07FFF);
        access(WR, 16'h4000);
        expect_out("R4 32K data external", 1, 1, 0, 1, 0, 8'h00, 17'h0);
        size_sel = 2'd2;
        access(RD, 16'hFFFF);
        expect_out("R3 128K data top", 0, 1, 1, 1, 0, 8'h00, 17'h1FFFF);
        access(FE, 16'hFFFF);
        expect_out("R2 128K fetch top", 0, 1, 1, 1, 0, 8'h00, 17'h0FFFF);
    endtask

    task automatic t_split;
        unsplit_mode = 0; size_sel = 2'd1; boundary = 5'd8; periph_en = 0;
        access(FE, 16'h3FFF);
        expect_out("R6 fetch below boundary", 0, 1, 1, 1, 0, 8'h00, 17'h03FFF);
        access(FE, 16'h4000);
        expect_out("R6 fetch at boundary", 1, 1, 1, 1, 1, 8'hFF, 17'h0);
        access(RD, 16'h4000);
        expect_out("R7 data at boundary", 0, 1, 1, 1, 0, 8'h00, 17'h04000);
        access(RD, 16'h1000);
        expect_out("R7 read in program region", 0, 1, 1, 1, 0, 8'h00, 17'h01000);
        access(WR, 16'h4000);
        expect_out("R7 write at boundary", 0, 0, 1, 1, 0, 8'h00, 17'h04000);
        size_sel = 2'd0;
        access(RD, 16'h8000);
        expect_out("R7 32K split external", 1, 1, 0, 1, 0, 8'h00, 17'h0);
        access(WR, 16'h7FFF);
        expect_out("R7 32K split write top", 0, 0, 1, 1, 0, 8'h00, 17'h07FFF);
    endtask

    task automatic t_protect;
        unsplit_mode = 0; size_sel = 2'd1; boundary = 5'd8; periph_en = 0;
        access(WR, 16'h3FFF);
        expect_out("R8 protected write", 1, 1, 1, 1, 1, 8'h00, 17'h0);
        access(NONE, 16'h0000);
        expect_out("R8 flag one cycle", 1, 1, 1, 1, 0, 8'h00, 17'h0);
    endtask

    task automatic t_rtc;
        unsplit_mode = 0; size_sel = 2'd1; boundary = 5'd28; periph_en = 1;
        access(WR, 16'hB123);
        expect_out("R9 window beats protection", 1, 1, 1, 0, 0, 8'h00, 17'h0);
        access(RD, 16'hBFFF);
        expect_out("R9 window top", 1, 1, 1, 0, 0, 8'h00, 17'h0);
        access(RD, 16'hC000);
        expect_out("R9 above window", 0, 1, 1, 1, 0, 8'h00, 17'h0C000);
        access(FE, 16'hB000);
        expect_out("R9 fetch ignores window", 0, 1, 1, 1, 0, 8'h00, 17'h0B000);
        periph_en = 0;
        access(WR, 16'hB123);
        expect_out("R9 window closed", 1, 1, 1, 1, 1, 8'h00, 17'h0);
    endtask

    task automatic t_largest;
        unsplit_mode = 0; size_sel = 2'd2; boundary = 5'd8; periph_en = 0;
        access(FE, 16'h8000);
        expect_out("R10 split ignored fetch", 0, 1, 1, 1, 0, 8'h00, 17'h08000);
        access(WR, 16'h1000);
        expect_out("R10 split ignored write", 0, 0, 1, 1, 0, 8'h00, 17'h11000);
        size_sel = 2'd3;
        access(RD, 16'h0000);
        expect_out("R10 select 3 as largest", 0, 1, 1, 1, 0, 8'h00, 17'h10000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_unsplit();
        t_split();
        t_protect();
        t_rtc();
        t_largest();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule